// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Saturating Direction Counters

This block sits next to the instruction fetch stage. In the same cycle that an instruction is fetched, it looks up the fetch address in a direct-mapped table. It returns the address to fetch next. Each table slot keeps four things: a valid flag, the upper address bits of the branch as a tag, the branch destination last seen, and a two-bit saturating direction counter. A taken branch that hits fetches its destination in the next cycle, with no bubble.

When a branch resolves in the execute stage, the pipeline returns three things on the resolve port: the actual outcome, the actual destination, and the prediction that was made for that branch at fetch. The block then writes the outcome into the table. It allocates a slot, steps the counter, or refreshes the destination. It also decides whether the earlier prediction was wrong. On a wrong prediction it raises a flush request for the two younger wrong-path instructions and steers fetch to the corrected address.

The resolve classifier has four named classes:
- IDLE: nothing resolved this cycle.
- GOOD: the prediction was right.
- DIR_MISS: the predicted direction was wrong.
- TGT_MISS: both said taken, but the destinations differ.

The counter FSM has four named states:
- SNT (00): strongly not taken.
- WNT (01): weakly not taken.
- WT (10): weakly taken.
- ST (11): strongly taken.

A taken outcome moves the counter SNT→WNT→WT→ST, and ST stays at ST. A not-taken outcome moves it ST→WT→WNT→SNT, and SNT stays at SNT.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses. With no redirect, next_pc is then fetch_pc+4 and pred_hit and pred_taken are 0.
- R2: The slot index is PC[IDX_W+1:2] and the tag is PC[ADDR_W-1:IDX_W+2]; the two lowest PC bits are ignored. A lookup hits only when the slot is valid and its tag equals the tag of the address.
- R3: Without a redirect, next_pc is chosen as follows:
  - On a miss, next_pc is fetch_pc+4.
  - On a hit whose counter is 00 or 01, next_pc is fetch_pc+4.
  - On a hit whose counter is 10 or 11, next_pc is the stored destination and pred_taken is 1.
- R4: A resolved taken branch that misses takes its slot. The slot becomes valid with the new tag and destination, and its counter starts at 10 (weakly taken).
- R5: A resolved not-taken branch that misses leaves the table unchanged.
- R6: On a hit update, the counter moves one step toward the outcome, using the encoding 00 SNT, 01 WNT, 10 WT, 11 ST. It stays at 11 on a taken outcome and at 00 on a not-taken outcome.
- R7: From a strong state, two consecutive opposite outcomes are needed to flip the predicted direction; one is not enough.
- R8: A resolved taken branch that hits overwrites the stored destination with the resolved destination.
- R9: flush_req is raised, only while res_valid is 1, in two cases: res_taken differs from res_pred_taken, or both are 1 and res_target differs from res_pred_target. redirect_pc is res_target when the branch was taken and res_pc+4 when it was not.
- R10: While flush_req is 1, next_pc equals redirect_pc, whatever the lookup returns.
- R11: When a lookup and an update hit the same slot in the same cycle, the lookup returns the contents from before the update.
- R12: A taken branch whose index matches a valid slot with a different tag replaces that slot. The old branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| next_pc | output | ADDR_W | Address to fetch next cycle |
| pred_hit | output | 1 | Lookup found a matching valid slot |
| pred_taken | output | 1 | Lookup predicts taken |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | ADDR_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_target | input | ADDR_W | Actual destination |
| res_pred_taken | input | 1 | Direction predicted at fetch |
| res_pred_target | input | ADDR_W | Destination predicted at fetch |
| flush_req | output | 1 | Flush the two younger instructions |
| redirect_pc | output | ADDR_W | Corrected fetch address |

## Verification
The bench walks one slot through all four counter states and pushes it against both saturation ends. A counter that wrapped would predict the wrong direction after the next step, and one that flipped on a single miss would predict wrong right after a strong state. A taken branch is aliased onto an occupied index and a byte-offset address is probed. A design that compared too few tag bits would then keep hitting on the wrong branch, and one that used the offset bits in the index would miss the right branch. Same-cycle lookup-and-update is exercised for both a fresh allocation and a counter step; a design that bypassed the write would show the new state one cycle early. A destination-only mismatch with agreeing directions, and a non-taken resolution on a missing slot, catch a missing target compare and a spurious allocation.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef enum logic [1:0] {
        RES_IDLE,
        RES_GOOD,
        RES_DIR_MISS,
        RES_TGT_MISS
    } res_e;
endpackage

// File: rtl/btb_ctr_step.sv
`timescale 1ns/1ps
module btb_ctr_step
    import btb_pkg::*;
(
    input  ctr_e cur,
    input  logic taken,
    output ctr_e nxt
);
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_SNT;
        endcase
    end
endmodule

// File: rtl/btb_table.sv
`timescale 1ns/1ps
module btb_table
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output ctr_e              rd_ctr,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int OFF   = 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF;

    logic [DEPTH-1:0]  valid_a;
    logic [TAG_W-1:0]  tag_a [DEPTH];
    logic [ADDR_W-1:0] tgt_a [DEPTH];
    ctr_e              ctr_a [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             wr_hit;
    ctr_e             wr_ctr_cur, wr_ctr_nxt;

    assign rd_idx = rd_pc[IDX_W+OFF-1:OFF];
    assign rd_tag = rd_pc[ADDR_W-1:IDX_W+OFF];
    assign wr_idx = wr_pc[IDX_W+OFF-1:OFF];
    assign wr_tag = wr_pc[ADDR_W-1:IDX_W+OFF];

    assign rd_hit    = valid_a[rd_idx] && (tag_a[rd_idx] == rd_tag);
    assign rd_ctr    = ctr_a[rd_idx];
    assign rd_target = tgt_a[rd_idx];

    assign wr_hit     = valid_a[wr_idx] && (tag_a[wr_idx] == wr_tag);
    assign wr_ctr_cur = ctr_a[wr_idx];

    btb_ctr_step u_step (
        .cur   (wr_ctr_cur),
        .taken (wr_taken),
        .nxt   (wr_ctr_nxt)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic              sel;
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [ADDR_W-1:0] g_q;
        ctr_e              c_q;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n)                          v_q <= 1'b0;
            else if (sel && (wr_hit || wr_taken)) v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                if (wr_hit) begin
                    c_q <= wr_ctr_nxt;
                    if (wr_taken) g_q <= wr_target;
                end else if (wr_taken) begin
                    t_q <= wr_tag;
                    g_q <= wr_target;
                    c_q <= CTR_WT;
                end
            end
        end

        assign valid_a[e] = v_q;
        assign tag_a[e]   = t_q;
        assign tgt_a[e]   = g_q;
        assign ctr_a[e]   = c_q;
    end

    // checker state: remembers the previous update
    logic             seen_q, chk_en_q, chk_taken_q, chk_hit_q, chk_vprev_q;
    logic [IDX_W-1:0] chk_idx_q;
    logic [TAG_W-1:0] chk_tag_q;
    ctr_e             chk_ctr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            chk_en_q <= 1'b0;
        end else begin
            seen_q   <= 1'b1;
            chk_en_q <= wr_en;
        end
        chk_taken_q <= wr_taken;
        chk_hit_q   <= wr_hit;
        chk_vprev_q <= valid_a[wr_idx];
        chk_idx_q   <= wr_idx;
        chk_tag_q   <= wr_tag;
        chk_ctr_q   <= wr_ctr_cur;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (valid_a == '0));

    p_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q && chk_taken_q) |-> (valid_a[chk_idx_q] && tag_a[chk_idx_q] == chk_tag_q));

    p_alloc_wt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q && chk_taken_q && !chk_hit_q) |-> (ctr_a[chk_idx_q] == CTR_WT));

    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q && !chk_taken_q && !chk_hit_q) |-> (valid_a[chk_idx_q] == chk_vprev_q));

    p_sat_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q && chk_hit_q && chk_taken_q && chk_ctr_q == CTR_ST) |-> (ctr_a[chk_idx_q] == CTR_ST));

    p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_q && chk_hit_q && !chk_taken_q && chk_ctr_q == CTR_SNT) |-> (ctr_a[chk_idx_q] == CTR_SNT));
endmodule

// File: rtl/btb_resolve.sv
`timescale 1ns/1ps
module btb_resolve
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              flush,
    output logic [ADDR_W-1:0] fix_pc
);
    res_e cls;

    always_comb begin
        if (!res_valid)                                     cls = RES_IDLE;
        else if (res_taken != res_pred_taken)               cls = RES_DIR_MISS;
        else if (res_taken && res_target != res_pred_target) cls = RES_TGT_MISS;
        else                                                cls = RES_GOOD;
    end

    always_comb begin
        unique case (cls)
            RES_IDLE, RES_GOOD:         flush = 1'b0;
            RES_DIR_MISS, RES_TGT_MISS: flush = 1'b1;
            default:                    flush = 1'b0;
        endcase
        fix_pc = res_taken ? res_target : res_pc + ADDR_W'(4);
    end
endmodule

// File: rtl/btb_predictor.sv
`timescale 1ns/1ps
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              flush_req,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    ctr_e              rd_ctr;
    logic [ADDR_W-1:0] rd_target;

    btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (fetch_pc),
        .rd_hit    (pred_hit),
        .rd_ctr    (rd_ctr),
        .rd_target (rd_target),
        .wr_en     (res_valid),
        .wr_pc     (res_pc),
        .wr_taken  (res_taken),
        .wr_target (res_target)
    );

    btb_resolve #(.ADDR_W(ADDR_W)) u_resolve (
        .res_valid       (res_valid),
        .res_pc          (res_pc),
        .res_taken       (res_taken),
        .res_target      (res_target),
        .res_pred_taken  (res_pred_taken),
        .res_pred_target (res_pred_target),
        .flush           (flush_req),
        .fix_pc          (redirect_pc)
    );

    assign pred_taken = pred_hit && (rd_ctr == CTR_WT || rd_ctr == CTR_ST);

    always_comb begin
        unique case ({flush_req, pred_taken})
            2'b10, 2'b11: next_pc = redirect_pc;
            2'b01:        next_pc = rd_target;
            default:      next_pc = fetch_pc + STEP;
        endcase
    end

    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && !pred_taken) |-> (next_pc == fetch_pc + STEP));

    p_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (next_pc == redirect_pc));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !flush_req);

    p_taken_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);
endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
    localparam int AW = 32;
    localparam int IW = 4;
    localparam int NE = 1 << IW;
    localparam logic [AW-1:0] IDLE_PC = 32'h0000_F000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] next_pc;
    logic          pred_hit, pred_taken;
    logic          res_valid = 1'b0;
    logic [AW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [AW-1:0] res_target = '0;
    logic          res_pred_taken = 1'b0;
    logic [AW-1:0] res_pred_target = '0;
    logic          flush_req;
    logic [AW-1:0] redirect_pc;

    always #5 clk = ~clk;

    btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) i_btb_predictor (
        .clk (clk), .rst_n (rst_n), .fetch_pc (fetch_pc), .next_pc (next_pc),
        .pred_hit (pred_hit), .pred_taken (pred_taken), .res_valid (res_valid),
        .res_pc (res_pc), .res_taken (res_taken), .res_target (res_target),
        .res_pred_taken (res_pred_taken), .res_pred_target (res_pred_target),
        .flush_req (flush_req), .redirect_pc (redirect_pc)
    );

    typedef struct packed {
        logic [AW-1:0] nxt;
        logic          hit;
        logic          tk;
        logic          fl;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // reference model built from the requirements
    logic          m_v   [NE];
    logic [AW-1:0] m_tag [NE];
    logic [AW-1:0] m_tgt [NE];
    logic [1:0]    m_ctr [NE];

    task automatic step(input logic [AW-1:0] fpc, input logic rv, input logic [AW-1:0] rpc,
                        input logic rt, input logic [AW-1:0] rtgt, input logic rpt,
                        input logic [AW-1:0] rptgt, input string req);
        exp_t e;
        int fi, ri;
        logic [AW-1:0] rd;
        @(posedge clk);
        #1;
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
        res_target = rtgt; res_pred_taken = rpt; res_pred_target = rptgt;
        fi = int'(fpc[IW+1:2]);
        e.hit = m_v[fi] && (m_tag[fi] == (fpc >> (IW + 2)));
        e.tk  = e.hit && m_ctr[fi][1];
        e.fl  = rv && ((rt != rpt) || (rt && rtgt != rptgt));
        rd    = rt ? rtgt : rpc + 32'd4;
        e.nxt = e.fl ? rd : (e.tk ? m_tgt[fi] : fpc + 32'd4);
        exp_q.push_back(e);
        req_q.push_back(req);
        if (rv) begin
            ri = int'(rpc[IW+1:2]);
            if (m_v[ri] && m_tag[ri] == (rpc >> (IW + 2))) begin
                if (rt) begin
                    m_ctr[ri] = (m_ctr[ri] == 2'b11) ? 2'b11 : m_ctr[ri] + 2'b01;
                    m_tgt[ri] = rtgt;
                end else begin
                    m_ctr[ri] = (m_ctr[ri] == 2'b00) ? 2'b00 : m_ctr[ri] - 2'b01;
                end
            end else if (rt) begin
                m_v[ri] = 1'b1; m_tag[ri] = rpc >> (IW + 2);
                m_tgt[ri] = rtgt; m_ctr[ri] = 2'b10;
            end
        end
    endtask

    task automatic look(input logic [AW-1:0] pc, input string req);
        step(pc, 1'b0, 32'h1234_5678, 1'b1, 32'h0BAD_0000, 1'b0, 32'h0, req);
    endtask

    task automatic res(input logic [AW-1:0] rpc, input logic rt, input logic [AW-1:0] rtgt,
                       input logic rpt, input logic [AW-1:0] rptgt, input string req);
        step(IDLE_PC, 1'b1, rpc, rt, rtgt, rpt, rptgt, req);
    endtask

    // monitor: compare in the middle of the cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_chk++;
            if (next_pc !== e.nxt || pred_hit !== e.hit || pred_taken !== e.tk || flush_req !== e.fl) begin
                n_bad++;
                $display("FAIL %s: got next=%h hit=%b tk=%b fl=%b, expected next=%h hit=%b tk=%b fl=%b",
                         r, next_pc, pred_hit, pred_taken, flush_req, e.nxt, e.hit, e.tk, e.fl);
            end
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'b00;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look(32'h0000_0100, "R1 empty after reset");
        look(32'h0000_0120, "R1 empty after reset");
        res(32'h0000_0200, 1'b0, 32'h0000_0300, 1'b0, 32'h0, "R5 not-taken miss");
        look(32'h0000_0200, "R5 no allocation");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b0, 32'h0, "R9 R10 direction miss");
        look(32'h0000_0120, "R4 allocated weakly taken");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100, "R9 correct no flush");
        res(32'h0000_0120, 1'b0, 32'h0000_0100, 1'b1, 32'h0000_0100, "R9 taken to not-taken redirect");
        look(32'h0000_0120, "R7 one miss keeps taken");
        res(32'h0000_0120, 1'b0, 32'h0, 1'b0, 32'h0, "R6 step down");
        look(32'h0000_0120, "R7 second miss flips");
        res(32'h0000_0120, 1'b0, 32'h0, 1'b0, 32'h0, "R6 to strong not taken");
        res(32'h0000_0120, 1'b0, 32'h0, 1'b0, 32'h0, "R6 hold at 00");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b0, 32'h0, "R6 step up");
        look(32'h0000_0120, "R6 low saturation");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b0, 32'h0, "R6 step up");
        look(32'h0000_0120, "R3 taken hit target");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100, "R6 to strong");
        res(32'h0000_0120, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100, "R6 hold at 11");
        res(32'h0000_0120, 1'b0, 32'h0, 1'b1, 32'h0000_0100, "R7 first opposite");
        look(32'h0000_0120, "R6 high saturation");
        res(32'h0000_0120, 1'b1, 32'h0000_0180, 1'b1, 32'h0000_0100, "R9 target miss");
        look(32'h0000_0120, "R8 new destination");
        look(32'h0000_0122, "R2 offset bits ignored");
        look(32'h0000_0160, "R2 tag mismatch");
        step(32'h0000_0120, 1'b0, 32'h0000_0120, 1'b0, 32'h0, 1'b1, 32'h0, "R9 res_valid low");
        look(32'h0000_0120, "R9 no update when idle");
        res(32'h0000_0520, 1'b1, 32'h0000_0600, 1'b0, 32'h0, "R12 alias allocation");
        look(32'h0000_0120, "R12 old branch evicted");
        look(32'h0000_0520, "R12 new branch hits");
        step(32'h0000_0520, 1'b1, 32'h0000_0520, 1'b0, 32'h0, 1'b0, 32'h0, "R11 lookup sees old");
        look(32'h0000_0520, "R11 update visible next cycle");
        step(32'h0000_0700, 1'b1, 32'h0000_0700, 1'b1, 32'h0000_0040, 1'b1, 32'h0000_0040, "R11 alloc same cycle");
        look(32'h0000_0700, "R4 allocation visible");
        look(32'h0000_0704, "R3 neighbour miss");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule